// File: doc/BRIEF.md
# Sliding-Window Sequence Detector

This block makes maximum-likelihood bit decisions for a binary channel whose received samples mix the current symbol with the two symbols before it. It does not run one unbroken Viterbi recursion with a traceback. Instead it cuts the sample stream into overlapping blocks of `WIN` samples. Each block is scored forward from its first sample and backward from its last sample. Decisions come only from the interior, so the `MARGIN` samples at each edge serve only to let the path metrics settle. Consecutive blocks are offset by `WIN - 2*MARGIN` samples, so the interiors tile the stream without gaps. No state carries from one block to the next, which means the work could be replicated or pipelined freely.

The user supplies quantized samples with a valid strobe. The user also supplies the noiseless level expected for each of the eight combinations of the current bit and the previous two bits. The block returns one word of interior decisions per block, with a one-cycle strobe. Channel estimation and the derivation of the levels are left to surrounding logic.

Top module: `sbv_detector`

## Requirements
- R1: A sample is taken only on a clock edge where `smp_vld_i` is high. The value on `smp_i` in any other cycle has no effect on any decision.
- R2: The first block is formed when the `WIN`-th sample is accepted (32 by default). After that, a new block is formed every `WIN-2*MARGIN` samples (16 by default). Block n covers accepted samples n*(WIN-2*MARGIN) through n*(WIN-2*MARGIN)+WIN-1, counting from 0.
- R3: Bit d of `dec_o` is the decision for the sample at position `MARGIN+d` of its block, so bit 0 belongs to the oldest interior sample. The first and last `MARGIN` samples (8 by default) produce no decisions.
- R4: Each decision is the value of that position in the bit sequence that minimises the sum over the block of (sample − level)², with both the starting state and the ending state of the block free. Sample k uses the level at `lvl_i[j*SW +: SW]`, where j = 4·x[k] + 2·x[k−1] + x[k−2]. Samples and levels are two's-complement.
- R5: If the best sequence with a 1 and the best sequence with a 0 at a position have equal cost, the decision is 0.
- R6: `dec_vld_o` is high for exactly one cycle. It rises (WIN−MARGIN)+(WIN−2·MARGIN) clock edges after the edge that accepts the last sample of the block (40 by default), and `dec_o` holds the block's word from that edge onward.
- R7: After normalisation, every stored path metric stays at or below 2·(2^SW−1)² for any input values.
- R8: While reset is applied and after its release, `dec_vld_o` and `dec_o` read 0 until the first block completes.
- R9: The block assumes input spacing such that no block is formed while the previous one is still being processed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | SW (6) | Signed quantized sample |
| lvl_i | input | 8·SW (48) | Signed expected level per branch, branch j in slice j |
| dec_vld_o | output | 1 | One-cycle strobe for a new decision word |
| dec_o | output | WIN−2·MARGIN (16) | Interior decisions, oldest in bit 0 |

## Verification
On every cycle, assertions enforce three properties: the bound on the normalised forward and backward metrics, the rule that a block never starts while the engine is busy, and the single-cycle strobe that appears only after a full block has been accepted. Only the bench scenarios can show whether the decisions themselves are right. The bench shows this by checking each reduced-size block against an exhaustive search over every bit sequence, including free edge states and the tie rule. It also confirms that a full-size noiseless stream is recovered bit-exact at the correct positions and latency, while junk values sit on the sample input between strobes.

// File: rtl/sbv_pkg.sv
package sbv_pkg;

  // engine phases: idle, metric sweep (both directions at once), serial decisions
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DEC  = 2'd2
  } sbv_state_e;

endpackage

// File: rtl/sbv_bmu.sv
// Branch metric unit: squared distance from one sample to every branch level.
module sbv_bmu #(
  parameter int SW  = 6,
  parameter int MEM = 2,
  parameter int BMW = 2*SW+2
) (
  input  logic [SW-1:0]                  smp_i,
  input  logic [(2<<MEM)*SW-1:0]         lvl_i,
  output logic [(2<<MEM)*BMW-1:0]        bm_o
);
  localparam int NB = 2 << MEM;

  for (genvar j = 0; j < NB; j++) begin : g_br
    logic signed [SW:0]      diff;
    logic signed [2*SW+1:0]  sq;
    assign diff = $signed({smp_i[SW-1], smp_i}) -
                  $signed({lvl_i[j*SW+SW-1], lvl_i[j*SW +: SW]});
    assign sq   = diff * diff;
    assign bm_o[j*BMW +: BMW] = BMW'($unsigned(sq));
  end

endmodule

// File: rtl/sbv_acs.sv
// Add-compare-select over the state trellis with per-step min normalisation.
// BACKWARD=0 recurses from the block start, BACKWARD=1 from the block end.
module sbv_acs #(
  parameter int SW       = 6,
  parameter int MEM      = 2,
  parameter int BMW      = 2*SW+2,
  parameter int MW       = BMW+1,
  parameter bit BACKWARD = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      en,
  input  logic [(2<<MEM)*BMW-1:0]   bm_i,
  output logic [(1<<MEM)*MW-1:0]    met_o
);
  localparam int NS  = 1 << MEM;
  localparam int HS  = NS / 2;
  localparam int CW  = MW + 1;
  localparam longint BND = 2 * ((longint'(1) << SW) - 1) * ((longint'(1) << SW) - 1);

  logic [NS*MW-1:0] met_q;
  logic [NS*MW-1:0] met_nxt;
  logic [CW-1:0]    cand0 [NS];
  logic [CW-1:0]    cand1 [NS];
  logic [CW-1:0]    best  [NS];
  logic [CW-1:0]    mn;

  for (genvar s = 0; s < NS; s++) begin : g_st
    if (!BACKWARD) begin : g_fw
      // predecessors of s are {s[MEM-2:0], x}; the arriving bit is s[MEM-1]
      localparam int P0 = (s % HS) * 2;
      localparam int BB = s / HS;
      assign cand0[s] = CW'(met_q[P0*MW +: MW]) + CW'(bm_i[(BB*NS+P0)*BMW +: BMW]);
      assign cand1[s] = CW'(met_q[(P0+1)*MW +: MW]) + CW'(bm_i[(BB*NS+P0+1)*BMW +: BMW]);
    end else begin : g_bw
      // successors of s are {b, s[MEM-1:1]}
      localparam int N0 = s / 2;
      localparam int N1 = HS + s / 2;
      assign cand0[s] = CW'(met_q[N0*MW +: MW]) + CW'(bm_i[s*BMW +: BMW]);
      assign cand1[s] = CW'(met_q[N1*MW +: MW]) + CW'(bm_i[(NS+s)*BMW +: BMW]);
    end

    AST_METRIC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      longint'(met_q[s*MW +: MW]) <= BND); // R7
  end

  always_comb begin
    mn = '1;
    for (int s = 0; s < NS; s++) begin
      best[s] = (cand1[s] < cand0[s]) ? cand1[s] : cand0[s];
      if (best[s] < mn) mn = best[s];
    end
    for (int s = 0; s < NS; s++) begin
      met_nxt[s*MW +: MW] = MW'(best[s] - mn);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    met_q <= '0;
    else if (clr)  met_q <= '0;
    else if (en)   met_q <= met_nxt;
  end

  assign met_o = met_q;

endmodule

// File: rtl/sbv_dec.sv
// Decision for one interior position: forward + branch + backward, best per bit value.
module sbv_dec #(
  parameter int SW  = 6,
  parameter int MEM = 2,
  parameter int BMW = 2*SW+2,
  parameter int MW  = BMW+1
) (
  input  logic [(1<<MEM)*MW-1:0]   fwd_i,
  input  logic [(1<<MEM)*MW-1:0]   bwd_i,
  input  logic [(2<<MEM)*BMW-1:0]  bm_i,
  output logic                     bit_o
);
  localparam int NS = 1 << MEM;
  localparam int HS = NS / 2;
  localparam int TW = MW + 2;

  logic [TW-1:0] tot0 [NS];
  logic [TW-1:0] tot1 [NS];
  logic [TW-1:0] min0, min1;

  for (genvar s = 0; s < NS; s++) begin : g_st
    assign tot0[s] = TW'(fwd_i[s*MW +: MW]) + TW'(bm_i[s*BMW +: BMW])
                   + TW'(bwd_i[(s/2)*MW +: MW]);
    assign tot1[s] = TW'(fwd_i[s*MW +: MW]) + TW'(bm_i[(NS+s)*BMW +: BMW])
                   + TW'(bwd_i[(HS+s/2)*MW +: MW]);
  end

  always_comb begin
    min0 = '1;
    min1 = '1;
    for (int s = 0; s < NS; s++) begin
      if (tot0[s] < min0) min0 = tot0[s];
      if (tot1[s] < min1) min1 = tot1[s];
    end
    bit_o = (min1 < min0);   // equal cost resolves to 0
  end

endmodule

// File: rtl/sbv_detector.sv
module sbv_detector #(
  parameter int SW     = 6,
  parameter int WIN    = 32,
  parameter int MARGIN = 8,
  parameter int MEM    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          smp_vld_i,
  input  logic [SW-1:0]                 smp_i,
  input  logic [(2<<MEM)*SW-1:0]        lvl_i,
  output logic                          dec_vld_o,
  output logic [WIN-2*MARGIN-1:0]       dec_o
);
  import sbv_pkg::*;

  localparam int C     = WIN - 2*MARGIN;
  localparam int NSTEP = WIN - MARGIN;
  localparam int NS    = 1 << MEM;
  localparam int NB    = 2 << MEM;
  localparam int BMW   = 2*SW + 2;
  localparam int MW    = BMW + 1;
  localparam int CNW   = $clog2(WIN);
  localparam int WIW   = $clog2(WIN);
  localparam int CTW   = $clog2(NSTEP);
  localparam int CIW   = (C > 1) ? $clog2(C) : 1;

  // reset: asserted asynchronously, released on the clock
  logic rst_m_q, rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_n <= rst_m_q;
    end
  end

  sbv_state_e        st_q, st_nxt;
  logic [CNW-1:0]    cnt_q, cnt_nxt;
  logic [CTW-1:0]    ctr_q, ctr_nxt;
  logic              vld_q, vld_nxt;
  logic [C-1:0]      dec_q, dec_nxt;
  logic [C-1:0]      bits_q, bits_fin;
  logic              trig, start, run, dec_ph, store;

  logic [SW-1:0]     sreg_q [WIN];
  logic [SW-1:0]     sreg_nxt [WIN];
  logic [SW-1:0]     win_q  [WIN];

  logic [WIW-1:0]    fsel, bsel;
  logic [CIW-1:0]    fw_idx, bw_idx, cidx;
  logic [NB*BMW-1:0] bm_f, bm_b;
  logic [NS*MW-1:0]  fmet, bmet;
  logic [NS*MW-1:0]  fst_q [C];
  logic [NS*MW-1:0]  bst_q [C];
  logic              dbit;

  assign trig   = smp_vld_i && (cnt_q == CNW'(WIN-1));
  assign start  = trig && (st_q == ST_IDLE);
  assign run    = (st_q == ST_RUN);
  assign dec_ph = (st_q == ST_DEC);
  assign store  = run && (ctr_q >= CTW'(MARGIN));

  // ---------------- sample line and block snapshot ----------------
  always_comb begin
    for (int i = 0; i < WIN-1; i++) sreg_nxt[i] = sreg_q[i+1];
    sreg_nxt[WIN-1] = smp_i;
  end

  always_ff @(posedge clk) begin
    if (smp_vld_i) sreg_q <= sreg_nxt;
    if (start)     win_q  <= sreg_nxt;
  end

  // ---------------- metric engines ----------------
  assign fsel   = run ? WIW'(ctr_q) : WIW'(ctr_q) + WIW'(MARGIN);
  assign bsel   = WIW'(WIN-1) - WIW'(ctr_q);
  assign fw_idx = CIW'(ctr_q - CTW'(MARGIN));
  assign bw_idx = CIW'(WIW'(WIN-1-MARGIN) - WIW'(ctr_q));
  assign cidx   = CIW'(ctr_q);

  sbv_bmu #(.SW(SW), .MEM(MEM), .BMW(BMW)) i_bmu_f (
    .smp_i (win_q[fsel]), .lvl_i (lvl_i), .bm_o (bm_f));

  sbv_bmu #(.SW(SW), .MEM(MEM), .BMW(BMW)) i_bmu_b (
    .smp_i (win_q[bsel]), .lvl_i (lvl_i), .bm_o (bm_b));

  sbv_acs #(.SW(SW), .MEM(MEM), .BMW(BMW), .MW(MW), .BACKWARD(1'b0)) i_acs_f (
    .clk (clk), .rst_n (rst_s_n), .clr (start), .en (run), .bm_i (bm_f), .met_o (fmet));

  sbv_acs #(.SW(SW), .MEM(MEM), .BMW(BMW), .MW(MW), .BACKWARD(1'b1)) i_acs_b (
    .clk (clk), .rst_n (rst_s_n), .clr (start), .en (run), .bm_i (bm_b), .met_o (bmet));

  always_ff @(posedge clk) begin
    if (store) begin
      fst_q[fw_idx] <= fmet;
      bst_q[bw_idx] <= bmet;
    end
  end

  // ---------------- serial decisions ----------------
  sbv_dec #(.SW(SW), .MEM(MEM), .BMW(BMW), .MW(MW)) i_dec (
    .fwd_i (fst_q[cidx]), .bwd_i (bst_q[cidx]), .bm_i (bm_f), .bit_o (dbit));

  always_comb begin
    bits_fin       = bits_q;
    bits_fin[cidx] = dbit;
  end

  always_ff @(posedge clk) begin
    if (dec_ph) bits_q <= bits_fin;
  end

  // ---------------- control ----------------
  always_comb begin
    cnt_nxt = cnt_q;
    st_nxt  = st_q;
    ctr_nxt = ctr_q;
    vld_nxt = 1'b0;
    dec_nxt = dec_q;
    if (smp_vld_i) cnt_nxt = trig ? CNW'(WIN-C) : cnt_q + 1'b1;
    unique case (st_q)
      ST_IDLE: if (trig) begin
        st_nxt  = ST_RUN;
        ctr_nxt = '0;
      end
      ST_RUN: if (ctr_q == CTW'(NSTEP-1)) begin
        st_nxt  = ST_DEC;
        ctr_nxt = '0;
      end else begin
        ctr_nxt = ctr_q + 1'b1;
      end
      ST_DEC: if (ctr_q == CTW'(C-1)) begin
        st_nxt  = ST_IDLE;
        ctr_nxt = '0;
        vld_nxt = 1'b1;
        dec_nxt = bits_fin;
      end else begin
        ctr_nxt = ctr_q + 1'b1;
      end
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ctr_q <= '0;
      vld_q <= 1'b0;
      dec_q <= '0;
    end else begin
      st_q  <= st_nxt;
      cnt_q <= cnt_nxt;
      ctr_q <= ctr_nxt;
      vld_q <= vld_nxt;
      dec_q <= dec_nxt;
    end
  end

  assign dec_vld_o = vld_q;
  assign dec_o     = dec_q;

  // ---------------- assertions ----------------
  logic [CNW:0] seen_q;
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)                                   seen_q <= '0;
    else if (smp_vld_i && seen_q != (CNW+1)'(WIN))  seen_q <= seen_q + 1'b1;
  end

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_s_n)
    trig |-> (st_q == ST_IDLE)); // R9

  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_s_n)
    dec_vld_o |=> !dec_vld_o); // R6

  AST_FIRST_WINDOW: assert property (@(posedge clk) disable iff (!rst_s_n)
    dec_vld_o |-> (seen_q == (CNW+1)'(WIN))); // R2

  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !dec_vld_o |-> $stable(dec_o)); // R6

endmodule

// File: tb/test_sbv_detector.sv
module test_sbv_detector;

  localparam int SW  = 6;
  // reduced configuration, checked against an exhaustive search
  localparam int WA  = 16, MA = 4, CA = WA - 2*MA, NWA = 6, NA = WA + CA*(NWA-1);
  localparam int LATA = (WA - MA) + CA;
  // default configuration, checked on a noiseless stream
  localparam int WB  = 32, MB = 8, CB = WB - 2*MB, NWB = 4, NBS = WB + CB*(NWB-1);
  localparam int LATB = (WB - MB) + CB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld_a = 1'b0, vld_b = 1'b0;
  logic [SW-1:0] smp_a = '0, smp_b = '0;
  logic [8*SW-1:0] lvl;
  logic dv_a, dv_b;
  logic [CA-1:0] dec_a;
  logic [CB-1:0] dec_b;

  always #10 clk = ~clk;

  sbv_detector #(.SW(SW), .WIN(WA), .MARGIN(MA), .MEM(2)) i_sbv_detector_small (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(vld_a), .smp_i(smp_a), .lvl_i(lvl),
    .dec_vld_o(dv_a), .dec_o(dec_a));

  sbv_detector i_sbv_detector (
    .clk(clk), .rst_n(rst_n), .smp_vld_i(vld_b), .smp_i(smp_b), .lvl_i(lvl),
    .dec_vld_o(dv_b), .dec_o(dec_b));

  int total = 0, bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int lv [8];
  int sa [NA];
  int sb [NBS];
  bit xa [NA+2];
  bit xb [NBS+2];
  logic [CA-1:0] exp_a [NWA];
  int acc_a [NA];
  int acc_b [NBS];
  int wa = 0, wb = 0, ties = 0;
  bit mon_en = 1'b0;

  task automatic chk(input bit ok, input string what, input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  function automatic int clampv(input int v);
    if (v > 31)  return 31;
    if (v < -32) return -32;
    return v;
  endfunction

  // exhaustive search over all WA+2 bits of one reduced block (R4, R5)
  function automatic logic [CA-1:0] brute(input int base);
    longint m0 [CA];
    longint m1 [CA];
    logic [CA-1:0] r;
    for (int k = 0; k < CA; k++) begin m0[k] = 64'h7fffffff; m1[k] = 64'h7fffffff; end
    for (int m = 0; m < (1 << (WA+2)); m++) begin
      longint met = 0;
      for (int i = 0; i < WA; i++) begin
        int j = ((m >> (i+2)) & 1)*4 + ((m >> (i+1)) & 1)*2 + ((m >> i) & 1);
        int d = sa[base+i] - lv[j];
        met += d*d;
      end
      for (int k = 0; k < CA; k++) begin
        if (((m >> (MA+k+2)) & 1) != 0) begin if (met < m1[k]) m1[k] = met; end
        else begin if (met < m0[k]) m0[k] = met; end
      end
    end
    for (int k = 0; k < CA; k++) begin
      r[k] = (m1[k] < m0[k]);
      if (m1[k] == m0[k]) ties++;
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (mon_en) begin
      if (dv_a) begin
        if (wa < NWA) begin
          chk(dec_a == exp_a[wa], $sformatf("R1 R3 R4 R5 R7 small block %0d bits", wa), dec_a, exp_a[wa]);
          chk(cyc == acc_a[wa*CA + WA - 1] + LATA, $sformatf("R6 small block %0d latency", wa),
              cyc, acc_a[wa*CA + WA - 1] + LATA);
        end else chk(1'b0, "R2 small extra block", wa, NWA);
        wa++;
      end
      if (dv_b) begin
        if (wb < NWB) begin
          logic [CB-1:0] e;
          for (int d = 0; d < CB; d++) e[d] = xb[wb*CB + MB + d + 2];
          chk(dec_b == e, $sformatf("R2 R3 R4 default block %0d bits", wb), dec_b, e);
          chk(cyc == acc_b[wb*CB + WB - 1] + LATB, $sformatf("R6 default block %0d latency", wb),
              cyc, acc_b[wb*CB + WB - 1] + LATB);
        end else chk(1'b0, "R2 default extra block", wb, NWB);
        wb++;
      end
    end
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    // levels: taps 12, 6, 3 on +/-1 symbols; index j = 4*x[k] + 2*x[k-1] + x[k-2]
    for (int j = 0; j < 8; j++) begin
      lv[j] = 12*(2*((j>>2)&1)-1) + 6*(2*((j>>1)&1)-1) + 3*(2*(j&1)-1);
      lvl[j*SW +: SW] = SW'(lv[j]);
    end
    for (int i = 0; i < NA+2; i++) begin
      lf = {lf[14:0], lf[15]^lf[13]^lf[12]^lf[10]};
      xa[i] = lf[0];
    end
    for (int i = 0; i < NBS+2; i++) begin
      lf = {lf[14:0], lf[15]^lf[13]^lf[12]^lf[10]};
      xb[i] = lf[3];
    end
    for (int i = 0; i < NA; i++) begin
      int nz;
      lf = {lf[14:0], lf[15]^lf[13]^lf[12]^lf[10]};
      nz = (i >= 2*CA && i < 3*CA+WA) ? (int'(lf[7:0]) % 27) - 13 : (int'(lf[7:0]) % 19) - 9;
      sa[i] = clampv(lv[xa[i+2]*4 + xa[i+1]*2 + xa[i]] + nz);
    end
    for (int i = 0; i < NBS; i++) sb[i] = lv[xb[i+2]*4 + xb[i+1]*2 + xb[i]];
    for (int n = 0; n < NWA; n++) exp_a[n] = brute(n*CA);

    // R8: reset state
    repeat (3) @(negedge clk);
    chk(dv_a == 1'b0 && dv_b == 1'b0, "R8 strobe in reset", {dv_a, dv_b}, 0);
    chk(dec_a == '0 && dec_b == '0, "R8 word in reset", dec_b, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dv_a == 1'b0 && dv_b == 1'b0, "R8 strobe after release", {dv_a, dv_b}, 0);
    chk(dec_a == '0 && dec_b == '0, "R8 word after release", dec_a, 0);
    mon_en = 1'b1;

    // one sample every 4 cycles (R9); junk on the sample bus when strobe is low (R1)
    for (int i = 0; i < NBS; i++) begin
      vld_b = 1'b1; smp_b = SW'(sb[i]); acc_b[i] = cyc + 1;
      if (i < NA) begin vld_a = 1'b1; smp_a = SW'(sa[i]); acc_a[i] = cyc + 1; end
      @(negedge clk);
      vld_a = 1'b0; vld_b = 1'b0;
      smp_a = (i % 2) ? 6'h1f : 6'h20;
      smp_b = (i % 2) ? 6'h20 : 6'h1f;
      repeat (3) @(negedge clk);
    end
    repeat (LATB + 10) @(negedge clk);
    chk(wa == NWA, "R2 small block count", wa, NWA);
    chk(wb == NWB, "R2 default block count", wb, NWB);
    $display("exhaustive search ties seen: %0d", ties);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule